// File: doc/BRIEF.md
# Power-Management Event Register Block

This block holds the power-management event state that system software reaches through a 64-byte I/O window. Inside the window sit four registers: a 16-bit event status register, a 16-bit event enable register, a 16-bit control register and a free-running count of the power-management timer. The block drives a level-sensitive system control interrupt (SCI) from status bits that are also enabled, plus a hotplug event bit supplied by a neighbouring general-purpose event block.

It also receives the legacy power-management command port. One command code switches ACPI mode on by setting the SCI enable bit in the control register, and another switches it off. Any command may also raise a one-cycle system-management interrupt (SMI) pulse, gated by a configuration bit. Four configuration bytes that govern this path are written through a small byte port. A build parameter can preset the "SMM already initialised" bit at reset.

The timer advances on an external tick strobe, normally at 3.579545 MHz. Each time its most significant bit changes, the timer status bit is set.

Top module: `pm_evt_regs`

## Requirements
- R1: An I/O access hits the window only while `cfg_dec_en_i` is 1 and `io_addr_i[15:6]` equals `cfg_base_i[15:6]` (the base masked with 0xFFC0). `io_rdata_o` is 0 whenever there is no read or no hit, and a write that misses changes nothing.
- R2: Register offsets are: status 0x00, enable 0x02, control 0x04, timer 0x08 (read-only, zero-extended). A read of any other offset returns 0, and a write to any other offset is ignored.
- R3: Status bit 0 is timer, bit 5 is global lock, bit 8 is power button and bit 10 is RTC. `gbl_evt_i`, `pwrbtn_i` and `rtc_evt_i` set bits 5, 8 and 10 on the next edge. Writing a 1 to a status bit clears it. When a set and a clear hit the same bit in the same cycle, the set wins. All other status bits read 0.
- R4: The enable register and the control register store all 16 written bits and read them back.
- R5: `sci_o` is 1 while (status & enable & 0x0521) is nonzero, or while both `gpe_hp_sts_i` and `gpe_hp_en_i` are 1. It follows a register write on the next edge.
- R6: An APM command 0xF1 sets control bit 0 and 0xF0 clears it, on the next edge. Other codes leave control unchanged. An APM command takes precedence over an I/O write to control bit 0 in the same cycle.
- R7: `smi_o` is a one-cycle pulse in the cycle after any APM command write, and it fires only when configuration byte 3 bit 1 (`cfg_smi_o[25]`) is 1.
- R8: Configuration byte i is written by `cfg_we_i` with `cfg_idx_i`=i and is visible at `cfg_smi_o[8i+7:8i]`. All bytes reset to 0, except that with `SMM_PRESET`=1 byte 3 resets to 0x02.
- R9: The timer resets to 0, increments by one per `tmr_tick_i` cycle and wraps at 2^TMR_W. Status bit 0 is set on every tick that changes the timer's most significant bit.
- R10: `tmr_arm_o` is 1 exactly while enable bit 0 is 1 and status bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 16 | I/O address |
| io_wr_i | input | 1 | I/O write strobe |
| io_rd_i | input | 1 | I/O read strobe |
| io_wdata_i | input | 16 | I/O write data |
| io_rdata_o | output | 32 | I/O read data (combinational) |
| cfg_base_i | input | 32 | Window base configuration value |
| cfg_dec_en_i | input | 1 | Window decode enable |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_idx_i | input | 2 | Configuration byte index |
| cfg_wdata_i | input | 8 | Configuration byte data |
| cfg_smi_o | output | 32 | The four configuration bytes |
| apm_wr_i | input | 1 | APM command write strobe |
| apm_cmd_i | input | 8 | APM command code |
| pwrbtn_i | input | 1 | Power-button event |
| rtc_evt_i | input | 1 | RTC alarm event |
| gbl_evt_i | input | 1 | Global-lock release event |
| gpe_hp_sts_i | input | 1 | Hotplug event status from the GPE block |
| gpe_hp_en_i | input | 1 | Hotplug event enable from the GPE block |
| tmr_tick_i | input | 1 | Timer increment strobe |
| sci_o | output | 1 | SCI level |
| smi_o | output | 1 | SMI pulse |
| tmr_arm_o | output | 1 | Timer interrupt source armed |

## Verification
The assertions assume single-cycle strobes on the I/O, APM and event inputs, and a window base and decode enable that change only while no access is in flight. They also assume that `io_rdata_o` is sampled only while `io_rd_i` is high. The stimulus raises every strobe for exactly one cycle from a quiet state. It changes the base and enable only between accesses, and it holds the GPE inputs steady across each check cycle. Event inputs are raised alone, or together with a status write only in the cycle that tests set-over-clear priority.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int OFF_STS = 'h00;
  localparam int OFF_EN  = 'h02;
  localparam int OFF_CTL = 'h04;
  localparam int OFF_TMR = 'h08;

  localparam int BIT_TMR = 0;
  localparam int BIT_GBL = 5;
  localparam int BIT_PWR = 8;
  localparam int BIT_RTC = 10;
  localparam logic [15:0] STS_MASK = 16'h0521;

  localparam int BIT_SCI_EN = 0;
  localparam logic [7:0] APM_ON  = 8'hF1;
  localparam logic [7:0] APM_OFF = 8'hF0;

  localparam int N_CFG       = 4;
  localparam int SMI_CFG_BIT = 8 * 3 + 1;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STS, SEL_EN, SEL_CTL, SEL_TMR
  } pm_sel_e;
endpackage

// File: rtl/pm_evt_decode.sv
module pm_evt_decode
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       base_i,
  input  logic              dec_en_i,
  output logic              hit_o,
  output pm_sel_e           sel_o
);
  logic [WIN_W-1:0] off;
  logic             unused_base;

  assign unused_base = ^{base_i[31:ADDR_W], base_i[WIN_W-1:0]};
  assign off   = addr_i[WIN_W-1:0];
  assign hit_o = dec_en_i && (addr_i[ADDR_W-1:WIN_W] == base_i[ADDR_W-1:WIN_W]);

  always_comb begin
    sel_o = SEL_NONE;
    if (hit_o) begin
      if      (off == WIN_W'(OFF_STS)) sel_o = SEL_STS;
      else if (off == WIN_W'(OFF_EN))  sel_o = SEL_EN;
      else if (off == WIN_W'(OFF_CTL)) sel_o = SEL_CTL;
      else if (off == WIN_W'(OFF_TMR)) sel_o = SEL_TMR;
    end
  end
endmodule

// File: rtl/pm_evt_timer.sv
module pm_evt_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             msb_flip_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // carry into the top bit toggles it
  assign msb_flip_o = tick_i && (&cnt_q[TMR_W-2:0]);
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/pm_evt_apm.sv
module pm_evt_apm
  import pm_evt_pkg::*;
#(
  parameter bit SMM_PRESET = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_idx_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              apm_wr_i,
  input  logic [7:0]        apm_cmd_i,
  output logic [8*N_CFG-1:0] cfg_o,
  output logic              acpi_on_o,
  output logic              acpi_off_o,
  output logic              smi_o
);
  for (genvar i = 0; i < N_CFG; i++) begin : g_cfg
    localparam logic [7:0] RST_VAL = (i == N_CFG - 1 && SMM_PRESET) ? 8'h02 : 8'h00;
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             byte_q <= RST_VAL;
      else if (cfg_we_i && cfg_idx_i == 2'(i)) byte_q <= cfg_wdata_i;
    end
    assign cfg_o[8*i +: 8] = byte_q;
  end

  logic smi_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smi_q <= 1'b0;
    else         smi_q <= apm_wr_i && cfg_o[SMI_CFG_BIT];
  end

  assign smi_o      = smi_q;
  assign acpi_on_o  = apm_wr_i && (apm_cmd_i == APM_ON);
  assign acpi_off_o = apm_wr_i && (apm_cmd_i == APM_OFF);
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_evt_pkg::*;
#(
  parameter int TMR_W      = 24,
  parameter bit SMM_PRESET = 1'b0,
  parameter int ADDR_W     = 16,
  parameter int WIN_W      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [15:0]       io_wdata_i,
  output logic [31:0]       io_rdata_o,
  input  logic [31:0]       cfg_base_i,
  input  logic              cfg_dec_en_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_idx_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [31:0]       cfg_smi_o,
  input  logic              apm_wr_i,
  input  logic [7:0]        apm_cmd_i,
  input  logic              pwrbtn_i,
  input  logic              rtc_evt_i,
  input  logic              gbl_evt_i,
  input  logic              gpe_hp_sts_i,
  input  logic              gpe_hp_en_i,
  input  logic              tmr_tick_i,
  output logic              sci_o,
  output logic              smi_o,
  output logic              tmr_arm_o
);
  logic             hit;
  pm_sel_e          sel;
  logic [TMR_W-1:0] tmr_cnt;
  logic             tmr_flip;
  logic             acpi_on, acpi_off;
  logic [15:0]      sts_q, en_q, ctl_q;
  logic [15:0]      sts_set, sts_clr, ctl_d;

  pm_evt_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_dec (
    .addr_i   (io_addr_i),
    .base_i   (cfg_base_i),
    .dec_en_i (cfg_dec_en_i),
    .hit_o    (hit),
    .sel_o    (sel)
  );

  pm_evt_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tmr_tick_i),
    .cnt_o      (tmr_cnt),
    .msb_flip_o (tmr_flip)
  );

  pm_evt_apm #(.SMM_PRESET(SMM_PRESET)) u_apm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_wdata_i (cfg_wdata_i),
    .apm_wr_i    (apm_wr_i),
    .apm_cmd_i   (apm_cmd_i),
    .cfg_o       (cfg_smi_o),
    .acpi_on_o   (acpi_on),
    .acpi_off_o  (acpi_off),
    .smi_o       (smi_o)
  );

  always_comb begin
    sts_set = '0;
    sts_set[BIT_TMR] = tmr_flip;
    sts_set[BIT_GBL] = gbl_evt_i;
    sts_set[BIT_PWR] = pwrbtn_i;
    sts_set[BIT_RTC] = rtc_evt_i;
    sts_clr = (io_wr_i && sel == SEL_STS) ? (io_wdata_i & STS_MASK) : '0;
  end

  always_comb begin
    ctl_d = (io_wr_i && sel == SEL_CTL) ? io_wdata_i : ctl_q;
    if (acpi_on)       ctl_d[BIT_SCI_EN] = 1'b1;
    else if (acpi_off) ctl_d[BIT_SCI_EN] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
      ctl_q <= '0;
    end else begin
      sts_q <= (sts_q & ~sts_clr) | sts_set;   // set beats clear
      if (io_wr_i && sel == SEL_EN) en_q <= io_wdata_i;
      ctl_q <= ctl_d;
    end
  end

  always_comb begin
    io_rdata_o = '0;
    if (io_rd_i) begin
      unique case (sel)
        SEL_STS: io_rdata_o = {16'h0, sts_q};
        SEL_EN:  io_rdata_o = {16'h0, en_q};
        SEL_CTL: io_rdata_o = {16'h0, ctl_q};
        SEL_TMR: io_rdata_o = 32'(tmr_cnt);
        default: io_rdata_o = '0;
      endcase
    end
  end

  assign sci_o     = (|(sts_q & en_q & STS_MASK)) || (gpe_hp_sts_i && gpe_hp_en_i);
  assign tmr_arm_o = en_q[BIT_TMR] && !sts_q[BIT_TMR];
endmodule

// File: rtl/pm_evt_chk.sv
module pm_evt_chk #(
  parameter int TMR_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             io_rd_i,
  input logic [31:0]      io_rdata_o,
  input logic             apm_wr_i,
  input logic [7:0]       apm_cmd_i,
  input logic             smi_o,
  input logic             smi_cfg_bit,
  input logic             sci_o,
  input logic             pwrbtn_i,
  input logic             tmr_tick_i,
  input logic [TMR_W-1:0] tmr_cnt,
  input logic [15:0]      sts_q,
  input logic [15:0]      en_q,
  input logic [15:0]      ctl_q
);
  p_rd_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |-> io_rdata_o == 32'h0);

  p_pwr_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrbtn_i |=> sts_q[8]);

  p_sci_pwr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q[8] && en_q[8]) |-> sci_o);

  p_apm_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apm_wr_i && apm_cmd_i == 8'hF1) |=> ctl_q[0]);

  p_apm_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apm_wr_i && apm_cmd_i == 8'hF0) |=> !ctl_q[0]);

  p_smi_fire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apm_wr_i && smi_cfg_bit) |=> smi_o);

  p_smi_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> ($past(apm_wr_i) && $past(smi_cfg_bit)));

  p_tmr_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_tick_i |=> tmr_cnt == TMR_W'($past(tmr_cnt) + 1'b1));

  p_tmr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_tick_i |=> $stable(tmr_cnt));
endmodule

bind pm_evt_regs pm_evt_chk #(.TMR_W(TMR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .io_rd_i     (io_rd_i),
  .io_rdata_o  (io_rdata_o),
  .apm_wr_i    (apm_wr_i),
  .apm_cmd_i   (apm_cmd_i),
  .smi_o       (smi_o),
  .smi_cfg_bit (cfg_smi_o[25]),
  .sci_o       (sci_o),
  .pwrbtn_i    (pwrbtn_i),
  .tmr_tick_i  (tmr_tick_i),
  .tmr_cnt     (tmr_cnt),
  .sts_q       (sts_q),
  .en_q        (en_q),
  .ctl_q       (ctl_q)
);

// File: tb/pm_evt_regs_tb.sv
module pm_evt_regs_tb;
  localparam int TW = 8;
  localparam logic [15:0] BASE = 16'hB0C0;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] io_addr = '0, io_wdata = '0;
  logic        io_wr = 0, io_rd = 0;
  logic [31:0] io_rdata, cfg_smi, strap_cfg;
  logic [31:0] cfg_base = 32'h1234_B0C7;
  logic        cfg_en = 1'b1, cfg_we = 0;
  logic [1:0]  cfg_idx = '0;
  logic [7:0]  cfg_wdata = '0, apm_cmd = '0;
  logic        apm_wr = 0, pwrbtn = 0, rtc = 0, gbl = 0, gsts = 0, gen = 0, tick = 0;
  logic        sci, smi, arm;
  logic        s_sci, s_smi, s_arm;
  logic [31:0] s_rdata;

  pm_evt_regs #(.TMR_W(TW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata), .cfg_base_i(cfg_base),
    .cfg_dec_en_i(cfg_en), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata),
    .cfg_smi_o(cfg_smi), .apm_wr_i(apm_wr), .apm_cmd_i(apm_cmd), .pwrbtn_i(pwrbtn),
    .rtc_evt_i(rtc), .gbl_evt_i(gbl), .gpe_hp_sts_i(gsts), .gpe_hp_en_i(gen),
    .tmr_tick_i(tick), .sci_o(sci), .smi_o(smi), .tmr_arm_o(arm)
  );

  pm_evt_regs #(.TMR_W(TW), .SMM_PRESET(1'b1)) u_strap (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(16'h0), .io_wr_i(1'b0), .io_rd_i(1'b0),
    .io_wdata_i(16'h0), .io_rdata_o(s_rdata), .cfg_base_i(32'h0), .cfg_dec_en_i(1'b0),
    .cfg_we_i(1'b0), .cfg_idx_i(2'd0), .cfg_wdata_i(8'h0), .cfg_smi_o(strap_cfg),
    .apm_wr_i(1'b0), .apm_cmd_i(8'h0), .pwrbtn_i(1'b0), .rtc_evt_i(1'b0),
    .gbl_evt_i(1'b0), .gpe_hp_sts_i(1'b0), .gpe_hp_en_i(1'b0), .tmr_tick_i(1'b0),
    .sci_o(s_sci), .smi_o(s_smi), .tmr_arm_o(s_arm)
  );

  typedef enum int {K_RD, K_SCI, K_SMI, K_ARM, K_CFG, K_STRAP} kind_e;
  typedef struct {
    kind_e       kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  // monitor: compares each queued item after the following clock edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          K_RD:    act = io_rdata;
          K_SCI:   act = {31'h0, sci};
          K_SMI:   act = {31'h0, smi};
          K_ARM:   act = {31'h0, arm};
          K_CFG:   act = cfg_smi;
          default: act = strap_cfg;
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  function automatic void push(kind_e k, logic [31:0] e, string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    q.push_back(it);
  endfunction

  task automatic idle();
    io_wr = 0; io_rd = 0; cfg_we = 0; apm_wr = 0;
    pwrbtn = 0; rtc = 0; gbl = 0; tick = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input int off, input logic [15:0] d);
    cyc(); io_addr = BASE + 16'(off); io_wdata = d; io_wr = 1;
  endtask

  task automatic rd_abs(input logic [15:0] a, input logic [31:0] e, input string t);
    cyc(); io_addr = a; io_rd = 1; push(K_RD, e, t);
  endtask

  task automatic rd(input int off, input logic [31:0] e, input string t);
    rd_abs(BASE + 16'(off), e, t);
  endtask

  task automatic see(input kind_e k, input logic [31:0] e, input string t);
    cyc(); push(k, e, t);
  endtask

  task automatic apm(input logic [7:0] c, input logic exp_smi, input string t);
    cyc(); apm_wr = 1; apm_cmd = c; push(K_SMI, {31'h0, exp_smi}, t);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(); tick = 1;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd('h00, 32'h0, "R3 reset status");
    rd('h02, 32'h0, "R4 reset enable");
    rd('h04, 32'h0, "R4 reset control");
    rd('h08, 32'h0, "R9 reset timer");
    see(K_CFG, 32'h0, "R8 reset cfg bytes");
    see(K_STRAP, 32'h0200_0000, "R8 strap preset");
    see(K_SCI, 32'h0, "R5 reset sci");

    // power button path
    wr('h02, 16'h0100);
    rd('h02, 32'h0100, "R4 enable readback");
    see(K_SCI, 32'h0, "R5 enabled but no status");
    cyc(); pwrbtn = 1;
    see(K_SCI, 32'h1, "R5 sci from power button");
    rd('h00, 32'h0100, "R3 power button status");
    wr('h00, 16'h0100);
    rd('h00, 32'h0, "R3 write-one-to-clear");
    see(K_SCI, 32'h0, "R5 sci drops after clear");
    cyc(); pwrbtn = 1; io_addr = BASE; io_wdata = 16'h0100; io_wr = 1;
    rd('h00, 32'h0100, "R3 set beats clear");
    wr('h00, 16'hFEFF);
    rd('h00, 32'h0100, "R3 writing zero keeps bit");

    // rtc and global lock, masking by enable
    cyc(); gbl = 1;
    rd('h00, 32'h0120, "R3 global lock status");
    wr('h02, 16'h0400);
    wr('h00, 16'h0100);
    see(K_SCI, 32'h0, "R5 unenabled status gives no sci");
    cyc(); rtc = 1;
    see(K_SCI, 32'h1, "R5 sci from rtc");
    rd('h00, 32'h0420, "R3 rtc status");
    wr('h00, 16'hFFFF);
    rd('h00, 32'h0, "R3 clear all");

    // gpe hotplug term
    cyc(); gsts = 1; gen = 0; push(K_SCI, 32'h0, "R5 gpe status only");
    cyc(); gsts = 1; gen = 1; push(K_SCI, 32'h1, "R5 gpe status and enable");
    cyc(); gsts = 0; gen = 0;

    // register storage and unmapped offsets
    wr('h02, 16'hABCD);
    rd('h02, 32'hABCD, "R4 enable full width");
    wr('h04, 16'h1234);
    rd('h04, 32'h1234, "R4 control full width");
    wr('h06, 16'hFFFF);
    rd('h06, 32'h0, "R2 unmapped read");
    rd('h0A, 32'h0, "R2 unmapped read 0x0a");
    wr('h08, 16'h00FF);
    rd('h08, 32'h0, "R2 timer is read-only");
    rd('h02, 32'hABCD, "R2 enable untouched by unmapped write");

    // decode
    rd_abs(BASE + 16'h0040, 32'h0, "R1 outside window");
    cyc(); cfg_en = 1'b0;
    rd('h02, 32'h0, "R1 decode disabled read");
    wr('h02, 16'h0000);
    cyc(); cfg_en = 1'b1;
    rd('h02, 32'hABCD, "R1 write while disabled ignored");

    // APM commands
    apm(8'hF1, 1'b0, "R7 no smi while cfg bit clear");
    rd('h04, 32'h1235, "R6 acpi on");
    apm(8'hF0, 1'b0, "R7 no smi on off command");
    rd('h04, 32'h1234, "R6 acpi off");
    apm(8'h55, 1'b0, "R7 no smi other code");
    rd('h04, 32'h1234, "R6 other code no effect");
    cyc(); cfg_we = 1; cfg_idx = 2'd3; cfg_wdata = 8'h02;
    see(K_CFG, 32'h0200_0000, "R8 cfg byte 3 write");
    cyc(); cfg_we = 1; cfg_idx = 2'd0; cfg_wdata = 8'h5A;
    see(K_CFG, 32'h0200_005A, "R8 cfg byte 0 write");
    apm(8'h55, 1'b1, "R7 smi pulse");
    see(K_SMI, 32'h0, "R7 smi lasts one cycle");
    cyc(); apm_wr = 1; apm_cmd = 8'hF1; io_addr = BASE + 16'h4; io_wdata = 16'h0; io_wr = 1;
    rd('h04, 32'h0001, "R6 apm beats io write");

    // timer
    wr('h02, 16'h0001);
    see(K_ARM, 32'h1, "R10 armed");
    ticks(127);
    rd('h08, 32'd127, "R9 count");
    rd('h00, 32'h0, "R9 no status before msb change");
    ticks(1);
    rd('h00, 32'h0001, "R9 status on msb change");
    see(K_SCI, 32'h1, "R5 sci from timer");
    see(K_ARM, 32'h0, "R10 disarmed by status");
    ticks(128);
    rd('h08, 32'h0, "R9 wrap");
    wr('h00, 16'h0001);
    see(K_ARM, 32'h1, "R10 rearmed after clear");
    wr('h02, 16'h0000);
    see(K_ARM, 32'h0, "R10 disarmed by enable");

    cyc(); cyc();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule